// File: doc/BRIEF.md
# SDRAM Single-Word Read Sequencer

This block turns one read request into the command train a synchronous DRAM needs for an isolated single-word read. It opens the row, issues a column read with a burst of one, and closes the row with an explicit precharge command rather than auto-precharge. It captures the returned word at CAS latency 2 and presents it with a one-cycle valid pulse. All device timing minimums are parameters given in picoseconds. At elaboration they are converted to clock counts by rounding up against the clock period.

Requests arrive on a valid/ready port carrying bank, row and column. The request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_valid` is high and `req_ready` is low, the requester must hold the payload stable, and only the values present at the accepting edge are used. `req_ready` stays low until the row-cycle and precharge-recovery windows allow the next row activation. A request held waiting is therefore accepted in exactly the first legal cycle. The read-data output has no back-pressure: the word is valid for the single cycle in which `rd_valid` is high.

Top module: `sdr_single_read`

## Requirements
- R1: During and after reset, with no request pending, the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `sd_cke` is 1, `sd_dqm` is 1, `req_ready` is 1 and `rd_valid` is 0. Reset is asynchronous and active low.
- R2: A request accepted at clock edge E puts ACTIVE (0011) on the pins in the cycle that follows E. In that cycle `sd_ba` carries the bank and `sd_addr` carries the row, zero-extended.
- R3: READ (0101) follows ACTIVE after RD = ceil(tRCD/tCK) cycles (2 with the defaults) and carries the same bank. Address bit 10 is 0 in that cycle, so auto-precharge is off. Column bits 9..0 are placed on address bits 9..0, and column bit 10 is placed on address bit 11.
- R4: `sd_dqm` is 0 in the READ cycle and 1 in every other cycle.
- R5: PRECHARGE (0010) follows ACTIVE after PRE = max(ceil(tRAS/tCK), RD+1) cycles (5 with the defaults) and carries the same bank. Address bit 10 equals the PRE_ALL parameter (1 closes every bank; default 0 closes only the selected bank).
- R6: `req_ready` is low from the accepting edge until the cycle before the next ACTIVE becomes legal. Two ACTIVE commands are therefore at least NXT = max(ceil(tRC/tCK), PRE + ceil(tRP/tCK)) cycles apart (8 with the defaults), and a held request is accepted exactly NXT cycles after the previous one.
- R7: The DQ word sampled at the clock edge CAS_LAT+1 edges after the start of the READ cycle appears on `rd_data`, with `rd_valid` high for exactly one cycle (ACTIVE + 5 with the defaults).
- R8: Every cycle that does not carry ACTIVE, READ or PRECHARGE carries NOP.
- R9: Payload changes made while a request is being served, or while a held request waits with `req_ready` low, have no effect on the commands of the request already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ADDR_W | Multiplexed row/column address |
| sd_dqm | output | 1 | Data mask, low only for the READ |
| sd_dq | input | DQ_W | Data from the memory |
| rd_data | output | DQ_W | Captured read word |
| rd_valid | output | 1 | One-cycle pulse with the captured word |

## Verification
The checker watches every cycle for the following. It confirms that only the four legal command codes appear and that CKE never drops. It confirms that address bit 10 is low on READ and matches the precharge scope on PRECHARGE, and that DQM is low on READ. It also measures the spacing of READ, PRECHARGE and the next ACTIVE from each ACTIVE, keeps `req_ready` low inside the row cycle, and keeps the data-valid signal to single pulses.

Other behaviours can only be shown by the bench's scenarios, because they depend on the request contents and on the memory model. These are whether the right row, bank and remapped column reach the bus, and whether the word captured is the one the memory drove in its CAS-latency slot. The same holds for the payload being ignored after acceptance and for a held request being taken in the first legal cycle.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_PRE = 4'b0010
  } sdr_cmd_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdr_col_map.sv
// Places a column address on the multiplexed bus, skipping bit 10
// which is reserved for the auto-precharge flag.
module sdr_col_map #(
  parameter int COL_W  = 11,
  parameter int ADDR_W = 13
) (
  input  logic [COL_W-1:0]  col,
  output logic [ADDR_W-1:0] addr
);
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i < 10 && i < COL_W) begin : g_low
      assign addr[i] = col[i];
    end else if (i > 10 && (i - 1) < COL_W) begin : g_high
      assign addr[i] = col[i-1];
    end else begin : g_zero
      assign addr[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sdr_rd_capture.sv
// Delays the READ marker by the CAS latency and samples the data bus.
module sdr_rd_capture #(
  parameter int CAS_LAT = 2,
  parameter int DQ_W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_on_bus,
  input  logic [DQ_W-1:0] dq,
  output logic [DQ_W-1:0] data,
  output logic            valid
);
  logic [CAS_LAT-1:0] slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot[0] <= 1'b0;
    else        slot[0] <= rd_on_bus;
  end

  for (genvar s = 1; s < CAS_LAT; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[s] <= 1'b0;
      else        slot[s] <= slot[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= slot[CAS_LAT-1];
      if (slot[CAS_LAT-1]) data <= dq;
    end
  end
endmodule

// File: rtl/sdr_single_read.sv
module sdr_single_read
  import sdr_rd_pkg::*;
#(
  parameter int TCK_PS   = 8000,
  parameter int TRCD_PS  = 15000,
  parameter int TRAS_PS  = 37000,
  parameter int TRP_PS   = 15000,
  parameter int TRC_PS   = 60000,
  parameter int CAS_LAT  = 2,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 11,
  parameter int ADDR_W   = 13,
  parameter int DQ_W     = 8,
  parameter bit PRE_ALL  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              sd_dqm,
  input  logic [DQ_W-1:0]   sd_dq,
  output logic [DQ_W-1:0]   rd_data,
  output logic              rd_valid
);
  localparam int RCD_C   = ceil_div(TRCD_PS, TCK_PS);
  localparam int RAS_C   = ceil_div(TRAS_PS, TCK_PS);
  localparam int RP_C    = ceil_div(TRP_PS, TCK_PS);
  localparam int RC_C    = ceil_div(TRC_PS, TCK_PS);
  localparam int RD_AT   = max2(RCD_C, 1);
  localparam int PRE_AT  = max2(RAS_C, RD_AT + 1);
  localparam int NEXT_AT = max2(RC_C, PRE_AT + RP_C);
  localparam int CNT_W   = $clog2(NEXT_AT + 1);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nx;
  logic              last;
  logic              accept;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [ADDR_W-1:0] col_bus;
  sdr_cmd_e          cmd_n, cmd_q;
  logic [BANK_W-1:0] ba_n;
  logic [ADDR_W-1:0] addr_n;

  assign last      = busy && (cnt == CNT_W'(NEXT_AT - 1));
  assign req_ready = !busy || last;
  assign accept    = req_valid && req_ready;
  assign cnt_nx    = cnt + 1'b1;

  sdr_col_map #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_col_map (
    .col  (col_q),
    .addr (col_bus)
  );

  // Command for the next cycle, chosen from the offset since ACTIVE.
  always_comb begin
    cmd_n  = CMD_NOP;
    ba_n   = '0;
    addr_n = '0;
    if (accept) begin
      cmd_n  = CMD_ACT;
      ba_n   = req_bank;
      addr_n = ADDR_W'(req_row);
    end else if (busy && !last) begin
      if (cnt_nx == CNT_W'(RD_AT)) begin
        cmd_n  = CMD_RD;
        ba_n   = bank_q;
        addr_n = col_bus;
      end else if (cnt_nx == CNT_W'(PRE_AT)) begin
        cmd_n      = CMD_PRE;
        ba_n       = bank_q;
        addr_n[10] = PRE_ALL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= '0;
      bank_q <= req_bank;
      col_q  <= req_col;
    end else if (busy) begin
      busy <= !last;
      cnt  <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_NOP;
      sd_ba   <= '0;
      sd_addr <= '0;
      sd_dqm  <= 1'b1;
    end else begin
      cmd_q   <= cmd_n;
      sd_ba   <= ba_n;
      sd_addr <= addr_n;
      sd_dqm  <= (cmd_n != CMD_RD);
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke = 1'b1;

  sdr_rd_capture #(.CAS_LAT(CAS_LAT), .DQ_W(DQ_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_on_bus (cmd_q == CMD_RD),
    .dq        (sd_dq),
    .data      (rd_data),
    .valid     (rd_valid)
  );
endmodule

// File: rtl/sdr_single_read_chk.sv
module sdr_single_read_chk
  import sdr_rd_pkg::*;
#(
  parameter int TCK_PS  = 8000,
  parameter int TRCD_PS = 15000,
  parameter int TRAS_PS = 37000,
  parameter int TRP_PS  = 15000,
  parameter int TRC_PS  = 60000,
  parameter int ADDR_W  = 13,
  parameter bit PRE_ALL = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              sd_dqm,
  input logic              rd_valid
);
  localparam int RD_AT   = max2(ceil_div(TRCD_PS, TCK_PS), 1);
  localparam int PRE_AT  = max2(ceil_div(TRAS_PS, TCK_PS), RD_AT + 1);
  localparam int NEXT_AT = max2(ceil_div(TRC_PS, TCK_PS), PRE_AT + ceil_div(TRP_PS, TCK_PS));
  localparam int SW      = $clog2(NEXT_AT + 1) + 1;

  logic [3:0]    cmd;
  logic [SW-1:0] since;
  logic          seen;

  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // Cycles since the most recent ACTIVE, saturating at the row-cycle limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      seen  <= 1'b0;
    end else if (cmd == CMD_ACT) begin
      since <= SW'(1);
      seen  <= 1'b1;
    end else if (since < SW'(NEXT_AT)) begin
      since <= since + 1'b1;
    end
  end

  p_cke_high_r1: assert property (@(posedge clk) disable iff (!rst_n) sd_cke);

  p_legal_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP) || (cmd == CMD_ACT) || (cmd == CMD_RD) || (cmd == CMD_PRE));

  p_read_a10_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD) |-> !sd_addr[10]);

  p_read_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD) |-> (seen && since == SW'(RD_AT)));

  p_dqm_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD) |-> !sd_dqm);

  p_dqm_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_RD) |-> sd_dqm);

  p_pre_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (seen && since == SW'(PRE_AT) && sd_addr[10] == PRE_ALL));

  p_act_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && seen) |-> (since >= SW'(NEXT_AT)));

  p_ready_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_ACT && seen && since < SW'(NEXT_AT - 1)) |-> !req_ready);

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind sdr_single_read sdr_single_read_chk #(
  .TCK_PS(TCK_PS), .TRCD_PS(TRCD_PS), .TRAS_PS(TRAS_PS), .TRP_PS(TRP_PS),
  .TRC_PS(TRC_PS), .ADDR_W(ADDR_W), .PRE_ALL(PRE_ALL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .sd_cke(sd_cke),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_addr(sd_addr), .sd_dqm(sd_dqm), .rd_valid(rd_valid)
);

// File: tb/sdr_single_read_tb.sv
`timescale 1ns/1ps
module sdr_single_read_tb;
  localparam int TCK  = 8000;
  localparam int CL   = 2;
  localparam int RD   = (15000 + TCK - 1) / TCK;
  localparam int RAS  = (37000 + TCK - 1) / TCK;
  localparam int RP   = (15000 + TCK - 1) / TCK;
  localparam int RC   = (60000 + TCK - 1) / TCK;
  localparam int PRE  = (RAS > RD + 1) ? RAS : RD + 1;
  localparam int NXT  = (RC > PRE + RP) ? RC : PRE + RP;
  localparam int DATA = RD + CL + 1;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RDC = 4'b0101, PRC = 4'b0010;

  // {bank, row, col}
  localparam logic [25:0] VEC [6] = '{
    {2'd0, 13'h0000, 11'h000}, {2'd1, 13'h1FFF, 11'h7FF},
    {2'd2, 13'h0A5A, 11'h400}, {2'd3, 13'h1234, 11'h3FF},
    {2'd1, 13'h0001, 11'h155}, {2'd2, 13'h1000, 11'h2AA}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, rd_valid;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;
  logic [7:0] sd_dq, rd_data;
  int n_chk = 0, n_err = 0, cyc = 0;

  always #4 clk = ~clk;

  sdr_single_read u_dut (.*);

  wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  function automatic logic [7:0] word(logic [1:0] b, logic [12:0] r, logic [10:0] c);
    return r[7:0] ^ c[7:0] ^ {r[12:8], c[10:8]} ^ {6'b0, b};
  endfunction

  // Memory model: word driven only in its CAS-latency slot.
  logic [1:0] m_bank; logic [12:0] m_row; logic [10:0] m_col; int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_cnt <= 0; m_bank <= '0; m_row <= '0; m_col <= '0; end
    else begin
      if (cmd == ACT) begin m_row <= sd_addr; m_bank <= sd_ba; end
      if (cmd == RDC) begin m_cnt <= 1; m_col <= {sd_addr[11], sd_addr[9:0]}; end
      else if (m_cnt == CL) m_cnt <= 0;
      else if (m_cnt != 0) m_cnt <= m_cnt + 1;
    end
  end
  assign sd_dq = (m_cnt == CL) ? word(m_bank, m_row, m_col) : ~word(m_bank, m_row, m_col);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Checks the cycles ACTIVE+1 .. ACTIVE+NXT-1 of one request.
  task automatic follow(input logic [1:0] b, input logic [12:0] r, input logic [10:0] c);
    for (int k = 1; k < NXT; k++) begin
      @(negedge clk);
      if (k == RD) begin
        check("R3 read cmd", cmd, RDC);
        check("R3 read bank", sd_ba, b);
        check("R3 read addr", sd_addr, {1'b0, c[10], 1'b0, c[9:0]});
        check("R4 dqm low on read", sd_dqm, 1'b0);
      end else if (k == PRE) begin
        check("R5 precharge cmd", cmd, PRC);
        check("R5 precharge bank", sd_ba, b);
        check("R5 precharge a10", sd_addr[10], 1'b0);
        check("R4 dqm high", sd_dqm, 1'b1);
      end else begin
        check("R8 nop", cmd, NOP);
        check("R4 dqm high", sd_dqm, 1'b1);
      end
      check("R7 valid timing", rd_valid, k == DATA);
      if (k == DATA) check("R7 data", rd_data, word(b, r, c));
      check("R6 ready window", req_ready, k == NXT - 1);
    end
  endtask

  task automatic run_one(input logic [1:0] b, input logic [12:0] r, input logic [10:0] c);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c;
    @(negedge clk);
    req_valid = 1'b0;
    req_bank = ~b; req_row = ~r; req_col = ~c;   // R9: changes after acceptance
    check("R2 active cmd", cmd, ACT);
    check("R2 active bank", sd_ba, b);
    check("R2 active row", sd_addr, r);
    check("R7 no valid at active", rd_valid, 1'b0);
    follow(b, r, c);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cmd", cmd, NOP);
    check("R1 reset cke", sd_cke, 1'b1);
    check("R1 reset dqm", sd_dqm, 1'b1);
    check("R1 reset valid", rd_valid, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle ready", req_ready, 1'b1);
    check("R1 idle cmd", cmd, NOP);

    foreach (VEC[i]) run_one(VEC[i][25:24], VEC[i][23:11], VEC[i][10:0]);

    // R6/R9: held request accepted exactly NXT cycles after the first.
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'd3; req_row = 13'h0777; req_col = 11'h0F0;
    @(negedge clk);
    check("R2 first active", cmd, ACT);
    req_bank = 2'd0; req_row = 13'h1ABC; req_col = 11'h50F;
    begin
      int act_at = 0;
      for (int k = 1; k <= NXT; k++) begin
        @(negedge clk);
        if (k == RD) check("R9 held payload ignored", sd_ba, 2'd3);
        if (k == DATA) check("R9 first data", rd_data, word(2'd3, 13'h0777, 11'h0F0));
        if (cmd == ACT && act_at == 0) act_at = k;
      end
      check("R6 back-to-back gap", act_at, NXT);
      check("R6 second bank", sd_ba, 2'd0);
    end
    req_valid = 1'b0;
    follow(2'd0, 13'h1ABC, 11'h50F);

    // R1: reset in the middle of a request.
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'd1; req_row = 13'h0042; req_col = 11'h011;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset cmd", cmd, NOP);
    check("R1 mid reset ready", req_ready, 1'b1);
    rst_n = 1'b1;
    repeat (NXT) begin
      @(negedge clk);
      check("R8 nop after reset", cmd, NOP);
      check("R7 no valid after reset", rd_valid, 1'b0);
    end
    run_one(2'd2, 13'h0F0F, 11'h7AA);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule